// File: doc/BRIEF.md
# Dual Bidirectional Expansion Port

This block adds two eight-bit general-purpose ports to a narrow command bus. A host selects one of four registers with a three-bit code, then either writes the shared eight-bit data bus into it with a write-enable pulse or reads it back while holding output-enable low. Each port has an output latch and a direction register. A pin whose direction bit is set is driven from the latch. A pin whose direction bit is clear is released and observed as an input.

Reading a port register returns a per-bit mix: the latch value for output bits and the synchronised live pin level for input bits. Reading a direction register returns its stored value. A high chip-enable blocks all register access but does not alter any stored state or pin drive. All strobes are sampled on the block clock. The write-enable rising edge is found by comparing the input with its value in the previous cycle.

Top module: `xport_dual`

## Requirements
- R1: Select code decoding: `rsel[2]` must be 1 to address a register. `rsel[1]` chooses the port (0 or 1) and `rsel[0]` chooses the direction register (1) or the output latch (0). Codes with `rsel[2]`=0 neither write nor read any register.
- R2: After reset both output latches hold 0xFF, both direction registers hold 0x00, `pad_oe` is all zero and `pad_out` is all ones.
- R3: Pin `k` of port `p` is driven (`pad_oe[p*8+k]`=1) with `pad_out[p*8+k]` equal to latch bit `k` exactly when direction bit `k` is 1. Each bit is set independently of the others.
- R4: Direction bits are independent, so a port can mix inputs and outputs. Writing one port's registers leaves the other port's registers unchanged.
- R5: A write takes `din` into the selected register at the clock edge where `we_n` is sampled high after being sampled low in the previous cycle, provided `ce_n` is low and a register code is selected. The new value appears at the pins right after that edge.
- R6: Reading a port latch code returns `(latch & dir) | (pin & ~dir)`, bit by bit.
- R7: While `ce_n` is high, writes have no effect and reads leave `dout_en` low. Latches, direction registers and pin drive keep their values.
- R8: Reading a direction register code returns the stored direction value.
- R9: Pin levels pass through two register stages before the read path. A pin change made in the same cycle that a held read starts first shows on `dout` at the third clock edge.
- R10: `dout` and `dout_en` are registered. One edge after a cycle with `oe_n` low, `ce_n` low and `rsel[2]` high, `dout_en` is 1 with the read value. Otherwise `dout_en` is 0 and `dout` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, the write happens on its rising edge |
| oe_n | input | 1 | Read strobe, active low |
| rsel | input | 3 | Register select code |
| din | input | 8 | Write data from the shared bus |
| dout | output | 8 | Registered read data |
| dout_en | output | 1 | High when `dout` should be driven onto the bus |
| pad_in | input | 16 | Pin levels, port 1 in bits 15:8 and port 0 in bits 7:0 |
| pad_out | output | 16 | Pin output values |
| pad_oe | output | 16 | Pin drive enables, 1 = driven |

## Verification
Two events can land in the same cycle: an external pin edge on an input-configured bit, and the start of a held port read. The bench changes `pad_in` on the same falling edge where it lowers `oe_n`. It then keeps the read held and samples `dout` after each of the next three rising edges. It expects the old pin value twice and the new value on the third. Deselected writes are judged at `pad_out`/`pad_oe` and by later reads of the same registers.

// File: rtl/xport_pkg.sv
package xport_pkg;
  localparam int SEL_W = 3;
  localparam int NPORT = 1 << (SEL_W - 2);

  typedef struct packed {
    logic hit;
    logic port;
    logic is_dir;
  } sel_t;

  function automatic sel_t decode_sel(input logic [SEL_W-1:0] code);
    sel_t s;
    s.hit    = code[2];
    s.port   = code[1];
    s.is_dir = code[0];
    return s;
  endfunction
endpackage

// File: rtl/xport_bank.sv
module xport_bank #(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce_n,
  input  logic         wr_out,
  input  logic         wr_dir,
  input  logic [W-1:0] din,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] mix
);
  logic [W-1:0] sync_q [SYNC];

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      dir_q   <= '0;
    end else begin
      if (wr_out) latch_q <= din;
      if (wr_dir) dir_q   <= din;
    end
  end

  for (genvar i = 0; i < SYNC; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[i] <= '0;
      else if (i == 0) sync_q[i] <= pad_in;
      else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
    end
  end

  assign mix = (latch_q & dir_q) | (sync_q[SYNC-1] & ~dir_q);

  assert_reset_vals_R2: assert property (@(posedge clk)
    $past(rst) |-> (latch_q == '1 && dir_q == '0));

  assert_write_latch_R5: assert property (@(posedge clk) disable iff (rst)
    wr_out |=> latch_q == $past(din));

  assert_deselect_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (ce_n && !rst) |=> ($stable(latch_q) && $stable(dir_q)));
endmodule

// File: rtl/xport_rdmux.sv
module xport_rdmux #(
  parameter int W     = 8,
  parameter int NPORT = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic               port,
  input  logic               is_dir,
  input  logic [NPORT*W-1:0] mix_all,
  input  logic [NPORT*W-1:0] dir_all,
  output logic [W-1:0]       dout,
  output logic               dout_en
);
  logic [W-1:0] rd_val;

  always_comb begin
    if (is_dir) rd_val = dir_all[int'(port)*W +: W];
    else        rd_val = mix_all[int'(port)*W +: W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout    <= rd_en ? rd_val : '0;
      dout_en <= rd_en;
    end
  end

  assert_dir_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_dir) |=> (dout_en && dout == $past(dir_all[int'(port)*W +: W])));
endmodule

// File: rtl/xport_dual.sv
module xport_dual
  import xport_pkg::*;
#(
  parameter int W    = 8,
  parameter int SYNC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_n,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic [SEL_W-1:0]   rsel,
  input  logic [W-1:0]       din,
  output logic [W-1:0]       dout,
  output logic               dout_en,
  input  logic [NPORT*W-1:0] pad_in,
  output logic [NPORT*W-1:0] pad_out,
  output logic [NPORT*W-1:0] pad_oe
);
  sel_t sel;
  logic we_q;
  logic wr_stb;
  logic rd_en;
  logic [NPORT*W-1:0] mix_all;
  logic [NPORT*W-1:0] dir_all;

  assign sel = decode_sel(rsel);

  always_ff @(posedge clk) begin
    if (rst) we_q <= 1'b1;
    else     we_q <= we_n;
  end

  assign wr_stb = we_n && !we_q && !ce_n && sel.hit;
  assign rd_en  = !oe_n && !ce_n && sel.hit;

  for (genvar p = 0; p < NPORT; p++) begin : g_bank
    logic wr_out_p, wr_dir_p;
    logic [W-1:0] latch_p, dir_p, mix_p;

    assign wr_out_p = wr_stb && (int'(sel.port) == p) && !sel.is_dir;
    assign wr_dir_p = wr_stb && (int'(sel.port) == p) &&  sel.is_dir;

    xport_bank #(.W(W), .SYNC(SYNC)) u_bank (
      .clk(clk), .rst(rst), .ce_n(ce_n),
      .wr_out(wr_out_p), .wr_dir(wr_dir_p), .din(din),
      .pad_in(pad_in[p*W +: W]),
      .latch_q(latch_p), .dir_q(dir_p), .mix(mix_p)
    );

    assign pad_out[p*W +: W] = latch_p;
    assign pad_oe[p*W +: W]  = dir_p;
    assign mix_all[p*W +: W] = mix_p;
    assign dir_all[p*W +: W] = dir_p;
  end

  xport_rdmux #(.W(W), .NPORT(NPORT)) u_rdmux (
    .clk(clk), .rst(rst), .rd_en(rd_en),
    .port(sel.port), .is_dir(sel.is_dir),
    .mix_all(mix_all), .dir_all(dir_all),
    .dout(dout), .dout_en(dout_en)
  );

  assert_bus_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !(!oe_n && !ce_n && rsel[2]) |=> (!dout_en && dout == '0));

  assert_no_sel_no_pin_change_R1: assert property (@(posedge clk) disable iff (rst)
    (!rsel[2] && !rst) |=> ($stable(pad_out) && $stable(pad_oe)));
endmodule

// File: tb/tb_xport_dual.sv
module tb_xport_dual;
  logic        clk = 0;
  logic        rst;
  logic        ce_n, we_n, oe_n;
  logic [2:0]  rsel;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en;
  logic [15:0] pad_in, pad_out, pad_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  xport_dual dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .rsel(rsel), .din(din), .dout(dout), .dout_en(dout_en),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] code, input logic [7:0] d, input logic cen);
    @(negedge clk);
    ce_n = cen; rsel = code; din = d; we_n = 0;
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    ce_n = 0;
  endtask

  task automatic rd(input logic [2:0] code, input logic cen,
                    output logic [7:0] d, output logic en);
    @(negedge clk);
    ce_n = cen; rsel = code; oe_n = 0;
    @(negedge clk);
    d = dout; en = dout_en;
    oe_n = 1; ce_n = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic en;
    check("R2 pad_oe", pad_oe, 16'h0000);
    check("R2 pad_out", pad_out, 16'hFFFF);
    check("R10 idle en", {15'b0, dout_en}, 16'h0);
    rd(3'b101, 0, d, en); check("R2 dir0", {8'h0, d}, 16'h00);
    rd(3'b111, 0, d, en); check("R2 dir1", {8'h0, d}, 16'h00);
    rd(3'b100, 0, d, en); check("R6 p0 input", {8'h0, d}, 16'h5A);
    rd(3'b110, 0, d, en); check("R6 p1 input", {8'h0, d}, 16'h3C);
    check("R10 read en", {15'b0, en}, 16'h1);
  endtask

  task automatic t_out_port0();
    logic [7:0] d; logic en;
    wr(3'b101, 8'hFF, 0);
    wr(3'b100, 8'h00, 0);
    check("R3 R5 pad_oe", pad_oe, 16'h00FF);
    check("R3 R5 pad_out", pad_out, 16'hFF00);
    rd(3'b100, 0, d, en); check("R6 p0 latch", {8'h0, d}, 16'h00);
  endtask

  task automatic t_mixed_port1();
    logic [7:0] d; logic en;
    wr(3'b111, 8'hF0, 0);
    wr(3'b110, 8'hA5, 0);
    check("R4 pad_oe", pad_oe, 16'hF0FF);
    check("R4 pad_out", pad_out, 16'hA500);
    rd(3'b110, 0, d, en); check("R6 R4 p1 mix", {8'h0, d}, 16'hAC);
    rd(3'b111, 0, d, en); check("R8 dir1", {8'h0, d}, 16'hF0);
    rd(3'b101, 0, d, en); check("R8 dir0", {8'h0, d}, 16'hFF);
  endtask

  task automatic t_deselect();
    logic [7:0] d; logic en;
    wr(3'b100, 8'h55, 1);
    wr(3'b111, 8'h0F, 1);
    check("R7 pad_out", pad_out, 16'hA500);
    check("R7 pad_oe", pad_oe, 16'hF0FF);
    rd(3'b100, 1, d, en); check("R7 read blocked", {15'b0, en}, 16'h0);
    check("R7 dout zero", {8'h0, d}, 16'h00);
    rd(3'b100, 0, d, en); check("R7 p0 kept", {8'h0, d}, 16'h00);
  endtask

  task automatic t_nosel();
    logic [7:0] d; logic en;
    wr(3'b011, 8'h12, 0);
    wr(3'b000, 8'h34, 0);
    check("R1 pad_out", pad_out, 16'hA500);
    check("R1 pad_oe", pad_oe, 16'hF0FF);
    rd(3'b010, 0, d, en); check("R1 R10 no read", {7'b0, en, d}, 16'h0000);
  endtask

  task automatic t_sync();
    wr(3'b101, 8'h00, 0);
    repeat (3) @(negedge clk);
    ce_n = 0; rsel = 3'b100; oe_n = 0; pad_in[7:0] = 8'hC3;
    @(negedge clk); check("R9 edge1 old", {8'h0, dout}, 16'h5A);
    @(negedge clk); check("R9 edge2 old", {8'h0, dout}, 16'h5A);
    @(negedge clk); check("R9 edge3 new", {8'h0, dout}, 16'hC3);
    oe_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; ce_n = 1; we_n = 1; oe_n = 1; rsel = 3'b000; din = 8'h00;
    pad_in = 16'h3C5A;
    repeat (4) @(negedge clk);
    rst = 0; ce_n = 0;
    repeat (3) @(negedge clk);
    t_reset();
    t_out_port0();
    t_mixed_port1();
    t_deselect();
    t_nosel();
    t_sync();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule